// File: doc/BRIEF.md
# Stream Frame CRC-32 Checker

This block sits on the receive side of a 32-bit AXI4-Stream link. It checks the integrity of every frame that passes. Each frame is a sequence of full 32-bit words. The first word is a header or address word, any number of payload words follow, and the frame closes with one word on the `tlast` beat that holds the sender's CRC-32. The checker runs the Ethernet CRC-32 over every word before that closing beat. When the closing beat arrives, it compares its own result with the closing word.

The result of each frame shows up on the cycle after the closing beat. A one-cycle `frame_done` pulse marks it, and a pass flag or a fail flag is set and then held until the next frame ends. A counter of frames that passed is kept, and it stops at its top value instead of wrapping. A second counter gives the number of words absorbed so far in the current frame. The checker never stalls the sender, and words that carry no bytes are skipped.

Top module: `axis_crc_frame_checker`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to its idle state. `crc_ok`, `crc_err`, `frame_done`, `good_cnt` and `beat_cnt` all read 0, and `s_tready` reads 1 at all times.
- R2: After reset is released, the block spends exactly one cycle in idle and then waits for a frame. A beat presented during that idle cycle is not consumed and produces no `frame_done`.
- R3: A beat is taken only on a rising edge where `s_tvalid` is 1. Cycles with `s_tvalid` at 0 inside a frame do not change the result.
- R4: A beat with `s_tvalid` at 1 and `s_tkeep` equal to 0 is a null beat. It is skipped entirely, even when `s_tlast` is 1.
- R5: The CRC is reflected CRC-32 with polynomial 0x04C11DB7, initial value 0xFFFFFFFF and final inversion. Bytes are processed in the order `tdata[7:0]`, `[15:8]`, `[23:16]`, `[31:24]`. The closing word matches when `tdata` equals the final CRC value.
- R6: On a matching closing beat, in the next cycle `frame_done` pulses for one cycle, `crc_ok` is 1, `crc_err` is 0 and `good_cnt` rises by exactly one.
- R7: On a mismatching closing beat, in the next cycle `frame_done` pulses, `crc_ok` is 0, `crc_err` is 1 and `good_cnt` is unchanged.
- R8: `crc_ok` and `crc_err` keep their values until the next frame ends. They are never both 1.
- R9: `beat_cnt` counts the non-closing words of the current frame, the header word included, and stops at 2^BEAT_W-1. It reads 0 from the cycle after a closing beat and while the block waits for a new frame.
- R10: `good_cnt` stops at 2^CNT_W-1 and stays there on further matching frames.
- R11: A frame made only of a closing beat is checked against the CRC of an empty message, which is 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_tdata | input | 32 | Stream data word |
| s_tkeep | input | 4 | Byte enables; all zero marks a null beat |
| s_tvalid | input | 1 | Beat valid |
| s_tlast | input | 1 | Closing beat carrying the CRC word |
| s_tready | output | 1 | Always high |
| frame_done | output | 1 | One-cycle pulse after each closing beat |
| crc_ok | output | 1 | Last frame matched |
| crc_err | output | 1 | Last frame mismatched |
| good_cnt | output | CNT_W | Saturating count of matching frames |
| beat_cnt | output | BEAT_W | Words absorbed in the current frame |

## Verification
The bench builds the block with CNT_W = 3 and BEAT_W = 3. With these values the pass counter tops out after seven good frames, and a frame of more than seven words hits the top of the word counter. Both saturation limits therefore come up early in a short sweep. The sweep runs every frame length from zero to nine payload words, in three beat patterns: back-to-back, with idle gaps, and with null beats. Pass and fail frames alternate.

// File: rtl/axis_crc_frame_checker.sv
module axis_crc_frame_checker #(
  parameter int CNT_W  = 11,
  parameter int BEAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       s_tdata,
  input  logic [3:0]        s_tkeep,
  input  logic              s_tvalid,
  input  logic              s_tlast,
  output logic              s_tready,
  output logic              frame_done,
  output logic              crc_ok,
  output logic              crc_err,
  output logic [CNT_W-1:0]  good_cnt,
  output logic [BEAT_W-1:0] beat_cnt
);

  localparam logic [31:0]       POLY_R    = 32'hEDB88320;
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;
  localparam logic [BEAT_W-1:0] BEAT_MAX  = '1;
  localparam logic [BEAT_W-1:0] BEAT_ONE  = BEAT_W'(1);

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DATA} st_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 32; i++)
      r = {1'b0, r[31:1]} ^ ((r[0] ^ d[i]) ? POLY_R : 32'h0);
    return r;
  endfunction

  st_t         st, st_nx;
  logic [31:0] crc_q;

  assign s_tready = 1'b1;

  wire beat  = s_tvalid && (s_tkeep != 4'h0) && (st != ST_IDLE);
  wire body  = beat && !s_tlast;
  wire fin   = beat && s_tlast;
  wire match = (s_tdata == ~crc_q);

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: st_nx = ST_HDR;
      ST_HDR:  if (body) st_nx = ST_DATA;
      ST_DATA: if (fin)  st_nx = ST_HDR;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      crc_q      <= '1;
      frame_done <= 1'b0;
      crc_ok     <= 1'b0;
      crc_err    <= 1'b0;
      good_cnt   <= '0;
      beat_cnt   <= '0;
    end else begin
      st         <= st_nx;
      frame_done <= fin;
      if (fin) begin
        crc_ok  <= match;
        crc_err <= !match;
        crc_q   <= '1;
        if (match && good_cnt != CNT_MAX) good_cnt <= good_cnt + 1'b1;
      end else if (body) begin
        crc_q <= crc_step(crc_q, s_tdata);
      end
      case (st)
        ST_HDR:  beat_cnt <= body ? BEAT_ONE : '0;
        ST_DATA: begin
          if (fin) beat_cnt <= '0;
          else if (body && beat_cnt != BEAT_MAX) beat_cnt <= beat_cnt + 1'b1;
        end
        default: beat_cnt <= '0;
      endcase
    end
  end

  assert_idle_exit_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |=> (st == ST_HDR));

  assert_skip_beat_R4: assert property (@(posedge clk) disable iff (rst)
    (!s_tvalid || s_tkeep == 4'h0) |=> ($stable(crc_q) && !frame_done));

  assert_single_step_R6: assert property (@(posedge clk) disable iff (rst)
    (good_cnt != $past(good_cnt)) |-> (good_cnt == $past(good_cnt) + 1'b1 && frame_done && crc_ok));

  assert_keep_count_R7: assert property (@(posedge clk) disable iff (rst)
    (fin && !match) |=> ($stable(good_cnt) && crc_err));

  assert_flags_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(crc_ok && crc_err));

  assert_wait_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HDR && !body) |=> (beat_cnt == '0));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    (good_cnt == CNT_MAX) |=> (good_cnt == CNT_MAX));

endmodule

// File: tb/axis_crc_frame_checker_tb_top.sv
`timescale 1ns/1ps
module axis_crc_frame_checker_tb_top;
  localparam int CW = 3;
  localparam int BW = 3;
  localparam int CMAX = (1 << CW) - 1;
  localparam int BMAX = (1 << BW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] tdata = '0;
  logic [3:0]  tkeep = 4'hF;
  logic tvalid = 1'b0, tlast = 1'b0;
  logic tready, fdone, ok, err;
  logic [CW-1:0] gcnt;
  logic [BW-1:0] bcnt;

  int checks = 0, failures = 0, exp_good = 0, frame_no = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  axis_crc_frame_checker #(.CNT_W(CW), .BEAT_W(BW)) dut_i (
    .clk(clk), .rst(rst), .s_tdata(tdata), .s_tkeep(tkeep), .s_tvalid(tvalid),
    .s_tlast(tlast), .s_tready(tready), .frame_done(fdone), .crc_ok(ok),
    .crc_err(err), .good_cnt(gcnt), .beat_cnt(bcnt));

  function automatic logic [31:0] crc_word(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r = c;
    for (int b = 0; b < 4; b++) begin
      r = r ^ {24'h0, w[8*b +: 8]};
      for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return r;
  endfunction

  task automatic chk(input bit cond, input string req, input longint act, input longint exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input bit v, input logic [3:0] k, input logic [31:0] d, input bit l);
    tvalid = v; tkeep = k; tdata = d; tlast = l;
    @(negedge clk);
    tvalid = 1'b0; tlast = 1'b0;
  endtask

  task automatic send_frame(input int n, input bit good, input int gm);
    logic [31:0] c = '1;
    logic [31:0] w;
    int exp_b;
    string rq;
    for (int i = 0; i < n; i++) begin
      w = (32'h9E3779B9 * (i + 1)) ^ (frame_no << 8);
      if (gm == 1 && i % 2 == 0) drive(0, 4'hF, ~w, 1);
      if (gm == 2 && i % 3 == 1) drive(1, 4'h0, ~c, 1);
      drive(1, 4'hF, w, 0);
      c = crc_word(c, w);
      exp_b = (i + 1 > BMAX) ? BMAX : i + 1;
      chk(bcnt == exp_b, "R9", bcnt, exp_b);
      chk(fdone == 0, (gm == 0) ? "R6" : (gm == 1 ? "R3" : "R4"), fdone, 0);
    end
    drive(1, 4'hF, good ? ~c : (~c ^ 32'h0001_0000), 1);
    chk(fdone == 1, "R6", fdone, 1);
    rq = (n == 0) ? "R11" : "R5";
    chk(ok == good, rq, ok, good);
    chk(err == !good, good ? "R6" : "R7", err, !good);
    if (good) begin
      rq = (exp_good == CMAX) ? "R10" : "R6";
      if (exp_good < CMAX) exp_good++;
    end else rq = "R7";
    chk(gcnt == exp_good, rq, gcnt, exp_good);
    chk(bcnt == 0, "R9", bcnt, 0);
    drive(0, 4'hF, 32'h0, 0);
    chk(fdone == 0, "R6", fdone, 0);
    chk(ok == good && err == !good, "R8", {ok, err}, {good, !good});
    frame_no++;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(ok == 0 && err == 0 && fdone == 0, "R1", {ok, err, fdone}, 0);
    chk(gcnt == 0 && bcnt == 0, "R1", {gcnt, bcnt}, 0);
    chk(tready == 1, "R1", tready, 1);
    rst = 1'b0;
    drive(1, 4'hF, 32'h0, 1);
    chk(fdone == 0 && gcnt == 0, "R2", {fdone, gcnt}, 0);
    drive(0, 4'hF, 32'h0, 0);
    chk(fdone == 0, "R2", fdone, 0);
    for (int n = 0; n <= 9; n++)
      for (int gm = 0; gm < 3; gm++)
        send_frame(n, ((n + gm) % 2) == 0, gm);
    for (int r = 0; r < 3; r++) send_frame(2, 1, 0);
    chk(gcnt == CMAX, "R10", gcnt, CMAX);
    drive(1, 4'h0, 32'h0, 1);
    chk(fdone == 0, "R4", fdone, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule